// File: doc/BRIEF.md
# Float to saturating integer converter

This block turns an unpacked floating-point operand into a signed two's-complement integer. The result is 32 bits wide by default, and a parameter widens it to 64. The operand arrives already unpacked. It carries a sign, a class code, an unbiased exponent, a mantissa with an explicit leading one at its top bit, and a sticky bit that stands for any bits dropped before this stage. The integer value of the operand is `mantissa * 2^(exponent - (MANT_W-1))`.

The block picks one of four rounding directions from a mode input. A force-truncate input overrides the mode and selects round-toward-zero, as a truncating convert instruction needs. The block tests for overflow after rounding. A value too large for the result width saturates and raises invalid-conversion. NaNs always saturate to the most negative integer.

Five exception flags come out with the integer: inexact, fraction-inexact, fraction-rounded, invalid-conversion and signalling-NaN. The result and the flags are registered once, so they appear one clock after the operand is presented.

Top module: `fp_to_int_sat`

## Requirements
- R1: A class code of 0 (zero) gives result 0 with all five flags clear, whatever the sign and rounding mode.
- R2: A normal operand whose exponent is OUT_W or more (32 by default), or a class code of 2 (infinity), saturates. A positive sign gives 0x7FFFFFFF and a negative sign gives 0x80000000. Invalid-conversion is raised and the inexact flags stay clear.
- R3: Class code 3 (quiet NaN), and any code from 5 to 7, gives 0x80000000 with invalid-conversion set, regardless of sign. Class code 4 (signalling NaN) gives the same result and also raises the signalling-NaN flag.
- R4: For class code 1 (normal), the bit just below the integer LSB is the guard bit. The OR of all lower mantissa bits and the sticky input is the round-sticky term. When both are zero, the result is exact and no flag is raised.
- R5: Mode 00 is round-to-nearest-even. The magnitude is incremented only when guard is set and either round-sticky is set or the truncated magnitude is odd.
- R6: Mode 01 never increments. Mode 10 increments any inexact positive value. Mode 11 increments any inexact negative value.
- R7: Overflow is decided on the rounded magnitude. A magnitude of 2^(OUT_W-1) plus the sign bit or more saturates as in R2. A negative magnitude of exactly 2^(OUT_W-1) gives 0x80000000 without invalid-conversion.
- R8: Inexact and fraction-inexact are both set for an inexact in-range result. Fraction-rounded is set when the magnitude was incremented. All three are clear whenever invalid-conversion is set.
- R9: A negative in-range operand returns the two's-complement negation of its rounded magnitude.
- R10: With force-truncate high, the conversion behaves as mode 01, whatever the mode input holds.
- R11: A negative exponent gives a truncated magnitude of 0. With exponent -1 the leading mantissa bit is the guard bit. With lower exponents the whole mantissa feeds the round-sticky term.
- R12: The result and flags are registered one clock after the inputs. A synchronous active-low reset clears all of them to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_class | input | 3 | Class code: 0 zero, 1 normal, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_exp | input | EXP_W | Unbiased exponent, two's complement |
| in_mant | input | MANT_W | Mantissa with explicit leading one at the top bit |
| in_sticky | input | 1 | OR of bits already discarded below the mantissa |
| rnd_mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| force_trunc | input | 1 | Forces toward-zero rounding |
| result | output | OUT_W | Signed integer result |
| flag_inexact | output | 1 | Result not exact |
| flag_frac_inexact | output | 1 | Fraction discarded |
| flag_frac_round | output | 1 | Magnitude was incremented |
| flag_invalid | output | 1 | Invalid conversion (overflow, infinity or NaN) |
| flag_snan | output | 1 | Signalling NaN operand |

## Verification
The hardest situations to reach are at the edge of the signed range, where the rounding increment itself decides overflow. A value just below 2^31 that rounds up must saturate when positive and pass as 0x80000000 when negative. Random operands almost never land on exponent 31 with the exact fraction pattern needed, so directed vectors build these ties, and the exact -2^31 value, bit by bit. Random stimulus then biases the exponent toward the span from -3 to 33, to exercise the guard position at every shift and the exponent threshold at both ends.

// File: rtl/fti_pkg.sv
// Shared encodings for the float-to-integer converter.
// Assumes the class and rounding-mode codes listed in the block brief.
package fti_pkg;
    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NORM = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } fti_class_e;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_POS     = 2'b10,
        RM_NEG     = 2'b11
    } fti_rmode_e;
endpackage

// File: rtl/fti_align.sv
// Aligns the mantissa so that the integer part, the guard bit and the
// round-sticky term can be read at fixed positions.
// Assumes the mantissa MSB carries weight 2^exp.
// Exponents of OUT_W or more are flagged as too big.
module fti_align #(
    parameter int OUT_W  = 32,
    parameter int MANT_W = 53,
    parameter int EXP_W  = 12
) (
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [MANT_W-1:0] mant_i,
    input  logic              sticky_i,
    output logic [OUT_W-1:0]  int_o,
    output logic              guard_o,
    output logic              rs_o,
    output logic              too_big_o
);
    localparam int TOT_W = OUT_W + MANT_W;
    localparam logic signed [EXP_W-1:0] LIM_EXP = EXP_W'(OUT_W);
    localparam logic signed [EXP_W-1:0] NEG_ONE = '1;

    logic signed [EXP_W-1:0] exp_s;
    logic [EXP_W-1:0]        shamt;
    logic [TOT_W-1:0]        ext;
    logic [TOT_W-1:0]        shifted;
    logic                    below;

    assign exp_s = exp_i;
    assign shamt = exp_i + EXP_W'(1);
    assign ext   = {{OUT_W{1'b0}}, mant_i};

    // Left-shift so that the integer LSB always lands at bit MANT_W
    always_comb begin
        too_big_o = (exp_s >= LIM_EXP);
        below     = (exp_s < NEG_ONE);
        if (too_big_o || below)
            shifted = ext;
        else
            shifted = ext << shamt;
    end

    // Pick integer, guard and round-sticky out of the aligned vector
    always_comb begin
        if (below) begin
            int_o   = '0;
            guard_o = 1'b0;
            rs_o    = (|mant_i) | sticky_i;
        end else begin
            int_o   = shifted[TOT_W-1:MANT_W];
            guard_o = shifted[MANT_W-1];
            rs_o    = (|shifted[MANT_W-2:0]) | sticky_i;
        end
    end
endmodule

// File: rtl/fti_round.sv
// Decides whether the truncated magnitude is incremented.
// Assumes the mode has already been forced to toward-zero when truncation is requested.
module fti_round
    import fti_pkg::*;
(
    input  fti_rmode_e mode_i,
    input  logic       sign_i,
    input  logic       lsb_i,
    input  logic       guard_i,
    input  logic       rs_i,
    output logic       inexact_o,
    output logic       bump_o
);
    // Apply the rounding direction to the guard and round-sticky terms
    always_comb begin
        inexact_o = guard_i | rs_i;
        unique case (mode_i)
            RM_NEAREST: bump_o = guard_i & (rs_i | lsb_i);
            RM_ZERO:    bump_o = 1'b0;
            RM_POS:     bump_o = inexact_o & ~sign_i;
            RM_NEG:     bump_o = inexact_o & sign_i;
            default:    bump_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/fti_pack.sv
// Forms the signed result and the exception flags from the class code,
// the rounded magnitude and the overflow test.
// Assumes class codes above CLS_SNAN behave as a quiet NaN.
module fti_pack
    import fti_pkg::*;
#(
    parameter int OUT_W = 32
) (
    input  fti_class_e       cls_i,
    input  logic             sign_i,
    input  logic             too_big_i,
    input  logic [OUT_W-1:0] int_i,
    input  logic             inexact_i,
    input  logic             bump_i,
    output logic [OUT_W-1:0] res_o,
    output logic [4:0]       flags_o
);
    localparam logic [OUT_W:0]   HALF    = (OUT_W+1)'(1) << (OUT_W-1);
    localparam logic [OUT_W-1:0] MAX_POS = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] MIN_NEG = {1'b1, {(OUT_W-1){1'b0}}};

    logic [OUT_W:0]   mag;
    logic [OUT_W:0]   limit;
    logic [OUT_W-1:0] signed_mag;
    logic             num_ovf;

    // Rounded magnitude and post-rounding range test
    always_comb begin
        mag        = {1'b0, int_i} + {{OUT_W{1'b0}}, bump_i};
        limit      = HALF + {{OUT_W{1'b0}}, sign_i};
        num_ovf    = too_big_i || (mag >= limit);
        signed_mag = sign_i ? (~mag[OUT_W-1:0]) + {{(OUT_W-1){1'b0}}, 1'b1}
                            : mag[OUT_W-1:0];
    end

    // Select result and flags by class; flags are {inx, fi, fr, inv, snan}
    always_comb begin
        unique case (cls_i)
            CLS_ZERO: begin
                res_o   = '0;
                flags_o = 5'b00000;
            end
            CLS_NORM: begin
                if (num_ovf) begin
                    res_o   = sign_i ? MIN_NEG : MAX_POS;
                    flags_o = 5'b00010;
                end else begin
                    res_o   = signed_mag;
                    flags_o = {inexact_i, inexact_i, bump_i, 2'b00};
                end
            end
            CLS_INF: begin
                res_o   = sign_i ? MIN_NEG : MAX_POS;
                flags_o = 5'b00010;
            end
            CLS_SNAN: begin
                res_o   = MIN_NEG;
                flags_o = 5'b00011;
            end
            default: begin
                res_o   = MIN_NEG;
                flags_o = 5'b00010;
            end
        endcase
    end
endmodule

// File: rtl/fp_to_int_sat.sv
// Top of the float-to-saturating-integer converter: selects the effective
// rounding mode, chains align, round and pack, and registers the outputs.
// Assumes an unpacked operand with an explicit leading one; latency one clock.
module fp_to_int_sat
    import fti_pkg::*;
#(
    parameter int OUT_W  = 32,
    parameter int MANT_W = 53,
    parameter int EXP_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_sign,
    input  logic [2:0]        in_class,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic [MANT_W-1:0] in_mant,
    input  logic              in_sticky,
    input  logic [1:0]        rnd_mode,
    input  logic              force_trunc,
    output logic [OUT_W-1:0]  result,
    output logic              flag_inexact,
    output logic              flag_frac_inexact,
    output logic              flag_frac_round,
    output logic              flag_invalid,
    output logic              flag_snan
);
    localparam logic [OUT_W-1:0] MAX_POS = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] MIN_NEG = {1'b1, {(OUT_W-1){1'b0}}};

    fti_rmode_e       eff_mode;
    logic [OUT_W-1:0] int_part;
    logic             guard, rs, too_big, inexact, bump;
    logic [OUT_W-1:0] res_next;
    logic [4:0]       flags_next;

    // Truncate request overrides the mode input
    assign eff_mode = force_trunc ? RM_ZERO : fti_rmode_e'(rnd_mode);

    fti_align #(.OUT_W(OUT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_align (
        .exp_i    (in_exp),
        .mant_i   (in_mant),
        .sticky_i (in_sticky),
        .int_o    (int_part),
        .guard_o  (guard),
        .rs_o     (rs),
        .too_big_o(too_big)
    );

    fti_round u_round (
        .mode_i   (eff_mode),
        .sign_i   (in_sign),
        .lsb_i    (int_part[0]),
        .guard_i  (guard),
        .rs_i     (rs),
        .inexact_o(inexact),
        .bump_o   (bump)
    );

    fti_pack #(.OUT_W(OUT_W)) u_pack (
        .cls_i    (fti_class_e'(in_class)),
        .sign_i   (in_sign),
        .too_big_i(too_big),
        .int_i    (int_part),
        .inexact_i(inexact),
        .bump_i   (bump),
        .res_o    (res_next),
        .flags_o  (flags_next)
    );

    // Output register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result            <= '0;
            flag_inexact      <= 1'b0;
            flag_frac_inexact <= 1'b0;
            flag_frac_round   <= 1'b0;
            flag_invalid      <= 1'b0;
            flag_snan         <= 1'b0;
        end else begin
            result <= res_next;
            {flag_inexact, flag_frac_inexact, flag_frac_round,
             flag_invalid, flag_snan} <= flags_next;
        end
    end

    AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_class == 3'd0) |=> (result == '0 && !flag_inexact && !flag_invalid && !flag_frac_round && !flag_snan)); // R1
    AST_SAT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        flag_invalid |-> (result == MAX_POS || result == MIN_NEG)); // R2
    AST_SNAN_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_class == 3'd4) |=> (flag_snan && flag_invalid && result == MIN_NEG)); // R3
    AST_NO_INEXACT_ON_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        flag_invalid |-> !(flag_inexact || flag_frac_inexact || flag_frac_round)); // R8
    AST_ROUND_IMPLIES_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
        flag_frac_round |-> (flag_inexact && flag_frac_inexact)); // R8
    AST_TRUNC_NO_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
        force_trunc |=> !flag_frac_round); // R10
endmodule

// File: tb/tb_fp_to_int_sat.sv
module tb_fp_to_int_sat;
    localparam int OW = 32;
    localparam int MW = 53;
    localparam int EW = 12;
    localparam logic [OW-1:0] MAXP = 32'h7FFF_FFFF;
    localparam logic [OW-1:0] MINN = 32'h8000_0000;
    localparam logic [MW-1:0] ONE  = 53'd1 << 52;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_sign = 1'b0;
    logic [2:0] in_class = 3'd0;
    logic [EW-1:0] in_exp = '0;
    logic [MW-1:0] in_mant = '0;
    logic in_sticky = 1'b0;
    logic [1:0] rnd_mode = 2'b00;
    logic force_trunc = 1'b0;
    logic [OW-1:0] result;
    logic flag_inexact, flag_frac_inexact, flag_frac_round, flag_invalid, flag_snan;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fp_to_int_sat #(.OUT_W(OW), .MANT_W(MW), .EXP_W(EW)) dut (
        .clk(clk), .rst_n(rst_n), .in_sign(in_sign), .in_class(in_class),
        .in_exp(in_exp), .in_mant(in_mant), .in_sticky(in_sticky),
        .rnd_mode(rnd_mode), .force_trunc(force_trunc), .result(result),
        .flag_inexact(flag_inexact), .flag_frac_inexact(flag_frac_inexact),
        .flag_frac_round(flag_frac_round), .flag_invalid(flag_invalid),
        .flag_snan(flag_snan)
    );

    // Reference conversion from the requirements; returns {result, inx, fi, fr, inv, snan}
    function automatic logic [OW+4:0] model(bit s, int cls, int e, logic [MW-1:0] mt,
                                            bit st, int md, bit ft);
        logic [127:0] m, tr, rem, half, mag, lim;
        logic [OW-1:0] r;
        int sh, mode;
        bit gt, eq, ex, up;
        mode = ft ? 1 : md;
        if (cls == 0) return '0;
        if (cls == 2) return {s ? MINN : MAXP, 5'b00010};
        if (cls == 4) return {MINN, 5'b00011};
        if (cls != 1) return {MINN, 5'b00010};
        if (e >= OW) return {s ? MINN : MAXP, 5'b00010};
        sh   = (MW - 1) - e;
        m    = 128'(mt);
        tr   = m >> sh;
        rem  = m - (tr << sh);
        half = 128'd1 << (sh - 1);
        gt   = (rem > half) || (rem == half && st);
        eq   = (rem == half) && !st;
        ex   = (rem == 0) && !st;
        case (mode)
            0: up = gt || (eq && tr[0]);
            1: up = 1'b0;
            2: up = !ex && !s;
            default: up = !ex && s;
        endcase
        mag = tr + 128'(up);
        lim = (128'd1 << (OW - 1)) + 128'(s);
        if (mag >= lim) return {s ? MINN : MAXP, 5'b00010};
        r = s ? OW'(128'd0 - mag) : mag[OW-1:0];
        return {r, !ex, !ex, up, 2'b00};
    endfunction

    // Drive one operand, wait for the registered output and compare
    task automatic apply(input bit s, input int cls, input int e, input logic [MW-1:0] mt,
                         input bit st, input int md, input bit ft,
                         input logic [OW+4:0] exp_v, input string tag);
        logic [OW+4:0] act;
        @(negedge clk);
        in_sign = s; in_class = 3'(cls); in_exp = EW'(e); in_mant = mt;
        in_sticky = st; rnd_mode = 2'(md); force_trunc = ft;
        @(posedge clk);
        @(negedge clk);
        act = {result, flag_inexact, flag_frac_inexact, flag_frac_round, flag_invalid, flag_snan};
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (s=%0d cls=%0d e=%0d m=%h st=%0d md=%0d ft=%0d)",
                     tag, act, exp_v, s, cls, e, mt, st, md, ft);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [OW+4:0] act;
        // R12: reset clears outputs even with a non-trivial operand at the inputs
        in_class = 3'd4; in_sign = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        act = {result, flag_inexact, flag_frac_inexact, flag_frac_round, flag_invalid, flag_snan};
        checks++;
        if (act !== '0) begin
            errors++;
            $display("FAIL R12 reset: actual %h expected %h", act, '0);
        end
        rst_n = 1'b1;

        // R1 zero
        apply(1, 0, 5, ONE, 1, 3, 0, '0, "R1 zero");
        // R2 exponent threshold and infinities
        apply(0, 1, 32, ONE, 0, 0, 0, {MAXP, 5'b00010}, "R2 exp32 pos");
        apply(1, 1, 100, ONE, 1, 0, 0, {MINN, 5'b00010}, "R2 big neg");
        apply(0, 2, 0, '0, 0, 0, 0, {MAXP, 5'b00010}, "R2 +inf");
        apply(1, 2, 0, '0, 0, 0, 0, {MINN, 5'b00010}, "R2 -inf");
        // R3 NaNs
        apply(0, 3, 0, ONE, 0, 0, 0, {MINN, 5'b00010}, "R3 qnan");
        apply(0, 4, 0, ONE, 0, 0, 0, {MINN, 5'b00011}, "R3 snan");
        apply(0, 6, 0, ONE, 0, 0, 0, {MINN, 5'b00010}, "R3 code6");
        // R7 range edge after rounding
        apply(1, 1, 31, ONE, 0, 0, 0, {MINN, 5'b00000}, "R7 exact -2^31");
        apply(0, 1, 31, ONE, 0, 0, 0, {MAXP, 5'b00010}, "R7 +2^31");
        apply(0, 1, 30, 53'hFFFF_FFFF << 21, 0, 0, 0, {MAXP, 5'b00010}, "R7 pos tie up overflow");
        apply(1, 1, 30, 53'hFFFF_FFFF << 21, 0, 0, 0, {MINN, 5'b11100}, "R7 neg tie up passes");
        // R5 nearest-even ties
        apply(0, 1, 0, ONE | (ONE >> 1), 0, 0, 0, {32'd2, 5'b11100}, "R5 1.5");
        apply(0, 1, 1, 53'd5 << 50, 0, 0, 0, {32'd2, 5'b11000}, "R5 2.5");
        apply(0, 1, 1, 53'd5 << 50, 1, 0, 0, {32'd3, 5'b11100}, "R5 2.5 sticky");
        // R11 negative exponents
        apply(0, 1, -1, ONE, 0, 0, 0, {32'd0, 5'b11000}, "R11 0.5 nearest");
        apply(0, 1, -1, ONE, 0, 2, 0, {32'd1, 5'b11100}, "R11 0.5 up");
        apply(1, 1, -5, ONE, 0, 3, 0, {32'hFFFF_FFFF, 5'b11100}, "R11 tiny neg down");
        apply(0, 1, -60, ONE, 0, 0, 0, {32'd0, 5'b11000}, "R11 exp -60");
        // R6 directions
        apply(1, 1, 0, ONE | (ONE >> 1), 0, 2, 0, {32'hFFFF_FFFF, 5'b11000}, "R6 -1.5 toward +inf");
        apply(1, 1, 0, ONE | (ONE >> 1), 0, 1, 0, {32'hFFFF_FFFF, 5'b11000}, "R6 -1.5 toward zero");
        // R10 force truncate beats nearest
        apply(0, 1, 0, ONE | (ONE >> 1) | (ONE >> 2), 0, 0, 1, {32'd1, 5'b11000}, "R10 1.75 trunc");
        // R4 exact and sticky-only
        apply(1, 1, 2, 53'd5 << 50, 0, 0, 0, {32'hFFFF_FFFB, 5'b00000}, "R4 R9 exact -5");
        apply(0, 1, 20, ONE, 1, 2, 0, {32'h0010_0001, 5'b11100}, "R4 sticky only");

        // Random operands, exponent biased to the interesting span
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 3000; i++) begin
            bit s, st, ft;
            int cls, e, md, sel;
            logic [MW-1:0] mt;
            s   = $urandom_range(0, 1);
            st  = ($urandom_range(0, 3) == 0);
            ft  = ($urandom_range(0, 7) == 0);
            md  = $urandom_range(0, 3);
            sel = $urandom_range(0, 15);
            cls = (sel < 13) ? 1 : $urandom_range(0, 7);
            e   = (sel < 11) ? $urandom_range(0, 36) - 3 : $urandom_range(0, 100) - 60;
            mt  = {1'b1, 20'($urandom()), 32'($urandom())};
            if ($urandom_range(0, 3) == 0) mt[20:0] = '0;
            apply(s, cls, e, mt, st, md, ft, model(s, cls, e, mt, st, md, ft), "R5 R6 R8 R9 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule